// File: doc/BRIEF.md
# Asynchronous Memory Cycle Sequencer

This block turns single word requests from the chip's internal logic into read or write cycles on an external asynchronous memory bus. Every cycle has three phases: address and select setup, an active-low strobe, and a hold phase. The length of each phase is counted in clock cycles and taken from a per-chip-select timing word. Reads and writes have their own three counts. The block drives the active-low chip enables, byte enables, word address, output enable, read and write strobes. During a write it also drives the outgoing data bus.

An external ready input can lengthen the strobe. This only happens when the effective setup and strobe counts together are at least 4. The input passes through a synchronizer and a retiming flop, so the strobe is released a fixed 3 clock edges after the first edge that sees ready high. Read data is captured at the end of the strobe and returned with a one-cycle acknowledge. After a cycle, the chip enable may stay asserted for a few extra cycles. A follow-on request to the same space then keeps it low without a gap.

Top module: `amem_seq`

## Requirements
- R1: While reset is high and right after it: every chip enable, the byte enables, output enable, read strobe and write strobe are high (inactive), the data drive enable is 0, ack is 0 and req_rdy is 1.
- R2: A read to space c uses the timing word at bits [c*24 +: 24] of cfg_timing. Inside it, 4-bit fields from the least significant end hold read setup, read strobe, read hold, write setup, write strobe and write hold. Setup lasts the read setup count, with CE[c], the byte enables (mem_be_n = ~req_be), the address and mem_oe_n low, and both strobes high. mem_re_n is then low for the read strobe count, and the selects stay valid for the read hold count.
- R3: A write uses the write counts in the same way. mem_we_n is the strobe, mem_oe_n stays high, and mem_dout carries req_wdata with mem_dout_en = 1 through setup, strobe and hold.
- R4: A setup or strobe count of 0 behaves as 1. A hold count of 0 gives no hold cycles.
- R5: When effective setup plus strobe is at least 4, the last strobe cycle repeats while mem_rdy is low. The strobe is released at the 3rd clock edge after the first edge that samples mem_rdy high, or at its programmed end if that is later.
- R6: When effective setup plus strobe is below 4, mem_rdy has no effect on strobe length.
- R7: For a read, rdata holds the value on mem_din during the last strobe cycle. ack is high for exactly one cycle, the cycle right after the last phase, and rdata is valid in that cycle.
- R8: When a cycle ends, the byte enables, output enable and data drive are released and mem_addr returns to 0. The chip enable stays low for CE_LINGER (default 3, at most 7) more cycles unless a new cycle starts first.
- R9: At most one chip enable is low at any time. A request accepted in the ack cycle to the same space keeps that chip enable low with no gap. One to another space moves the enable over on the same edge.
- R10: A request is taken only on a clock edge where req and req_rdy are both high. req_rdy is low from the acceptance edge until the ack cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_timing | input | NUM_CS*24 | Timing words, one per chip-select space |
| req | input | 1 | Request valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_cs | input | CS_W | Target chip-select space |
| req_addr | input | ADDR_W | Word address |
| req_be | input | BE_W | Byte enables, active high |
| req_wdata | input | DATA_W | Write data |
| req_rdy | output | 1 | Sequencer idle, request can be taken |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Read data, valid with ack |
| mem_ce_n | output | NUM_CS | Chip enables, active low |
| mem_be_n | output | BE_W | Byte enables, active low |
| mem_addr | output | ADDR_W | Word address |
| mem_oe_n | output | 1 | Output enable, active low, reads only |
| mem_re_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dout | output | DATA_W | Outgoing data |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | DATA_W | Incoming data |
| mem_rdy | input | 1 | Asynchronous ready from memory |

## Verification
The assertions check, on every cycle, the properties that hold at any single moment. Only one chip enable is low. A write strobe is always covered by data drive. ack never lasts two cycles. A frozen strobe holds while the retimed ready is low. A strobe with stretching disabled ends on its count. The phase counter never reaches zero while busy. The bench scenarios cover the things that need whole cycles to show. These are the exact setup, strobe and hold lengths for each space and direction, zero counts, ready released late versus early, and ready held low where it must be ignored. They also cover read data returning with ack, the linger length of the chip enable, and back-to-back requests to the same space and to different spaces.

// File: rtl/amem_pkg.sv
package amem_pkg;
  localparam int TCNT_W = 4;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

  // least significant field first: rs, rst, rh, ws, wst, wh
  typedef struct packed {
    logic [TCNT_W-1:0] wh;
    logic [TCNT_W-1:0] wst;
    logic [TCNT_W-1:0] ws;
    logic [TCNT_W-1:0] rh;
    logic [TCNT_W-1:0] rst;
    logic [TCNT_W-1:0] rs;
  } tcfg_t;

  localparam int TCFG_W = $bits(tcfg_t);

  function automatic logic [TCNT_W-1:0] at_least_one(input logic [TCNT_W-1:0] v);
    return (v == '0) ? TCNT_W'(1) : v;
  endfunction
endpackage

// File: rtl/amem_rdy_sync.sv
module amem_rdy_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic rdy_in,
  output logic rdy_out
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[STAGES-2:0], rdy_in};
  end

  assign rdy_out = shreg[STAGES-1];
endmodule

// File: rtl/amem_phase_ctl.sv
module amem_phase_ctl
  import amem_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   start_we,
  input  tcfg_t  start_cfg,
  input  logic   rdy_q,
  output phase_e phase,
  output phase_e phase_nxt,
  output logic   cap,
  output logic   done
);
  tcfg_t             cfg_q;
  logic              we_q;
  logic [TCNT_W-1:0] cnt, cnt_nxt;
  logic [TCNT_W-1:0] s_eff, t_eff, h_cnt, s_start;
  logic [TCNT_W:0]   st_sum;
  logic              stretch_en;

  assign s_eff   = at_least_one(we_q ? cfg_q.ws  : cfg_q.rs);
  assign t_eff   = at_least_one(we_q ? cfg_q.wst : cfg_q.rst);
  assign h_cnt   = we_q ? cfg_q.wh : cfg_q.rh;
  assign s_start = at_least_one(start_we ? start_cfg.ws : start_cfg.rs);
  assign st_sum  = {1'b0, s_eff} + {1'b0, t_eff};
  assign stretch_en = st_sum >= (TCNT_W+1)'(4);

  always_comb begin
    phase_nxt = phase;
    cnt_nxt   = cnt;
    cap       = 1'b0;
    done      = 1'b0;
    case (phase)
      PH_IDLE: if (start) begin
        phase_nxt = PH_SETUP;
        cnt_nxt   = s_start;
      end
      PH_SETUP: begin
        if (cnt == TCNT_W'(1)) begin
          phase_nxt = PH_STROBE;
          cnt_nxt   = t_eff;
        end else cnt_nxt = cnt - TCNT_W'(1);
      end
      PH_STROBE: begin
        if (cnt != TCNT_W'(1)) cnt_nxt = cnt - TCNT_W'(1);
        else if (!stretch_en || rdy_q) begin
          cap = 1'b1;
          if (h_cnt == '0) begin
            phase_nxt = PH_IDLE;
            done      = 1'b1;
          end else begin
            phase_nxt = PH_HOLD;
            cnt_nxt   = h_cnt;
          end
        end
      end
      default: begin
        if (cnt == TCNT_W'(1)) begin
          phase_nxt = PH_IDLE;
          done      = 1'b1;
        end else cnt_nxt = cnt - TCNT_W'(1);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      cfg_q <= '0;
      we_q  <= 1'b0;
    end else begin
      phase <= phase_nxt;
      cnt   <= cnt_nxt;
      if (start && phase == PH_IDLE) begin
        cfg_q <= start_cfg;
        we_q  <= start_we;
      end
    end
  end

  // R4
  cnt_live_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |-> (cnt != '0));

  // R5
  strobe_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STROBE && stretch_en && cnt == TCNT_W'(1) && !rdy_q) |=> (phase == PH_STROBE));

  // R6
  no_stretch_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STROBE && !stretch_en && cnt == TCNT_W'(1)) |=> (phase != PH_STROBE));
endmodule

// File: rtl/amem_ce_hold.sv
module amem_ce_hold #(
  parameter int LINGER = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic done,
  output logic keep_nxt
);
  localparam int CW = $clog2(LINGER + 2);

  logic [CW-1:0] lcnt, lcnt_nxt;

  always_comb begin
    if (start)            lcnt_nxt = '0;
    else if (done)        lcnt_nxt = CW'(LINGER);
    else if (lcnt != '0)  lcnt_nxt = lcnt - CW'(1);
    else                  lcnt_nxt = lcnt;
  end

  assign keep_nxt = (lcnt_nxt != '0);

  always_ff @(posedge clk) begin
    if (rst) lcnt <= '0;
    else     lcnt <= lcnt_nxt;
  end

  // R8
  linger_bound_chk: assert property (@(posedge clk) disable iff (rst)
    lcnt <= CW'(LINGER));
endmodule

// File: rtl/amem_seq.sv
module amem_seq
  import amem_pkg::*;
#(
  parameter int NUM_CS      = 4,
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 32,
  parameter int BE_W        = 4,
  parameter int CE_LINGER   = 3,
  parameter int SYNC_STAGES = 3,
  localparam int CS_W       = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CS*TCFG_W-1:0] cfg_timing,
  input  logic                     req,
  input  logic                     req_we,
  input  logic [CS_W-1:0]          req_cs,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [BE_W-1:0]          req_be,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     req_rdy,
  output logic                     ack,
  output logic [DATA_W-1:0]        rdata,
  output logic [NUM_CS-1:0]        mem_ce_n,
  output logic [BE_W-1:0]          mem_be_n,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic                     mem_oe_n,
  output logic                     mem_re_n,
  output logic                     mem_we_n,
  output logic [DATA_W-1:0]        mem_dout,
  output logic                     mem_dout_en,
  input  logic [DATA_W-1:0]        mem_din,
  input  logic                     mem_rdy
);
  tcfg_t cfg_arr [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cfg
    assign cfg_arr[g] = cfg_timing[g*TCFG_W +: TCFG_W];
  end

  phase_e phase, phase_nxt;
  logic   start, cap, done, rdy_q, keep_nxt, act_nxt;

  logic              we_q;
  logic [CS_W-1:0]   cs_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] wd_q;

  logic              nx_we;
  logic [CS_W-1:0]   nx_cs;
  logic [ADDR_W-1:0] nx_addr;
  logic [BE_W-1:0]   nx_be;
  logic [DATA_W-1:0] nx_wd;
  logic [NUM_CS-1:0] nx_oh;

  assign req_rdy = (phase == PH_IDLE);
  assign start   = req && req_rdy;

  amem_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .rdy_in  (mem_rdy),
    .rdy_out (rdy_q)
  );

  amem_phase_ctl u_phase (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .start_we  (req_we),
    .start_cfg (cfg_arr[req_cs]),
    .rdy_q     (rdy_q),
    .phase     (phase),
    .phase_nxt (phase_nxt),
    .cap       (cap),
    .done      (done)
  );

  amem_ce_hold #(.LINGER(CE_LINGER)) u_ce (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .done     (done),
    .keep_nxt (keep_nxt)
  );

  assign nx_we   = start ? req_we    : we_q;
  assign nx_cs   = start ? req_cs    : cs_q;
  assign nx_addr = start ? req_addr  : addr_q;
  assign nx_be   = start ? req_be    : be_q;
  assign nx_wd   = start ? req_wdata : wd_q;
  assign nx_oh   = NUM_CS'(1) << nx_cs;
  assign act_nxt = (phase_nxt != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q   <= 1'b0;
      cs_q   <= '0;
      addr_q <= '0;
      be_q   <= '0;
      wd_q   <= '0;
    end else if (start) begin
      we_q   <= req_we;
      cs_q   <= req_cs;
      addr_q <= req_addr;
      be_q   <= req_be;
      wd_q   <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ce_n    <= '1;
      mem_be_n    <= '1;
      mem_addr    <= '0;
      mem_oe_n    <= 1'b1;
      mem_re_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_dout    <= '0;
      mem_dout_en <= 1'b0;
      ack         <= 1'b0;
      rdata       <= '0;
    end else begin
      mem_ce_n    <= (act_nxt || keep_nxt) ? ~nx_oh : '1;
      mem_be_n    <= act_nxt ? ~nx_be : '1;
      mem_addr    <= act_nxt ? nx_addr : '0;
      mem_oe_n    <= !(act_nxt && !nx_we);
      mem_re_n    <= !(phase_nxt == PH_STROBE && !nx_we);
      mem_we_n    <= !(phase_nxt == PH_STROBE && nx_we);
      mem_dout    <= (act_nxt && nx_we) ? nx_wd : '0;
      mem_dout_en <= act_nxt && nx_we;
      ack         <= done;
      if (cap && !we_q) rdata <= mem_din;
    end
  end

  // R2
  strobe_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_re_n || !mem_we_n) |-> (mem_ce_n != '1 && (mem_re_n || mem_we_n)));

  // R3
  wdata_drv_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_dout_en && mem_oe_n));

  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R9
  ce_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_ce_n));

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req && req_rdy) |=> !req_rdy);
endmodule

// File: tb/amem_seq_test.sv
module amem_seq_test;
  import amem_pkg::*;

  localparam int NUM_CS = 4;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 32;
  localparam int BE_W   = 4;
  localparam int LINGER = 3;
  localparam int CS_W   = 2;
  localparam logic [DATA_W-1:0] MAGIC = 32'hA5C3_0F1E;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [NUM_CS*TCFG_W-1:0] cfg_timing;
  logic req = 1'b0, req_we = 1'b0;
  logic [CS_W-1:0] req_cs = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [BE_W-1:0] req_be = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_rdy, ack;
  logic [DATA_W-1:0] rdata, mem_dout, mem_din;
  logic [NUM_CS-1:0] mem_ce_n;
  logic [BE_W-1:0] mem_be_n;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_oe_n, mem_re_n, mem_we_n, mem_dout_en;
  logic mem_rdy = 1'b1;

  tcfg_t cfgs [NUM_CS];
  always_comb for (int i = 0; i < NUM_CS; i++) cfg_timing[i*TCFG_W +: TCFG_W] = cfgs[i];

  // memory model: read value derived from the word address
  assign mem_din = DATA_W'(mem_addr) ^ MAGIC;

  amem_seq #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W),
             .CE_LINGER(LINGER)) uut (
    .clk(clk), .rst(rst), .cfg_timing(cfg_timing),
    .req(req), .req_we(req_we), .req_cs(req_cs), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .req_rdy(req_rdy), .ack(ack),
    .rdata(rdata), .mem_ce_n(mem_ce_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
    .mem_oe_n(mem_oe_n), .mem_re_n(mem_re_n), .mem_we_n(mem_we_n),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din),
    .mem_rdy(mem_rdy));

  typedef struct {
    int cs; bit we;
    logic [ADDR_W-1:0] addr; logic [BE_W-1:0] be; logic [DATA_W-1:0] wd;
    int s; int t; int h; int str; string stag;
  } item_t;

  item_t exq[$];
  int total = 0, bad = 0;
  int rdy_target = 0, rdy_cnt = 0;
  bit watch = 0;
  int gap = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int eff(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  function automatic item_t mk(input int cs, input bit we, input logic [ADDR_W-1:0] a,
                               input logic [BE_W-1:0] be, input logic [DATA_W-1:0] wd,
                               input int L);
    item_t it;
    bit en;
    it.cs = cs; it.we = we; it.addr = a; it.be = be; it.wd = wd;
    it.s = eff(we ? int'(cfgs[cs].ws)  : int'(cfgs[cs].rs));
    it.t = eff(we ? int'(cfgs[cs].wst) : int'(cfgs[cs].rst));
    it.h = we ? int'(cfgs[cs].wh) : int'(cfgs[cs].rh);
    en = (it.s + it.t) >= 4;
    it.str = it.t;
    it.stag = we ? "R3" : "R2";
    if (L > 0) begin
      it.stag = en ? "R5" : "R6";
      if (en && L + 3 > it.t) it.str = L + 3;
    end
    return it;
  endfunction

  task automatic drive(input item_t it);
    req_cs = CS_W'(it.cs); req_we = it.we; req_addr = it.addr;
    req_be = it.be; req_wdata = it.wd;
  endtask

  task automatic xfer(input int cs, input bit we, input logic [ADDR_W-1:0] a,
                      input logic [BE_W-1:0] be, input logic [DATA_W-1:0] wd, input int L);
    item_t it;
    it = mk(cs, we, a, be, wd, L);
    exq.push_back(it);
    if (L > 0) begin
      mem_rdy = 1'b0; rdy_cnt = 0; rdy_target = L;
      repeat (4) @(negedge clk);
    end else begin
      mem_rdy = 1'b1; rdy_target = 0;
    end
    drive(it);
    req = 1'b1;
    @(posedge clk); #1 req = 1'b0;
    while (exq.size() != 0) @(negedge clk);
    mem_rdy = 1'b1; rdy_target = 0;
    repeat (10) @(negedge clk);
  endtask

  task automatic b2b(input item_t a, input item_t b);
    exq.push_back(a);
    exq.push_back(b);
    mem_rdy = 1'b1; rdy_target = 0;
    drive(a);
    req = 1'b1;
    @(posedge clk); #1;
    drive(b);
    watch = 1; gap = 0;
    do @(negedge clk); while (!req_rdy);
    @(posedge clk); #1 req = 1'b0;
    while (exq.size() != 0) @(negedge clk);
    watch = 0;
    chk(gap == 0, "R9", "chip enable gap between back-to-back cycles", gap, 0);
    repeat (10) @(negedge clk);
  endtask

  // ready driver: raise ready after a given number of strobe-low samples
  always @(negedge clk) begin
    if (rdy_target > 0 && (!mem_re_n || !mem_we_n)) begin
      rdy_cnt++;
      if (rdy_cnt == rdy_target) mem_rdy = 1'b1;
    end
    if (watch && mem_ce_n == '1) gap++;
  end

  // monitor / scoreboard
  item_t cur;
  bit was_busy = 0, busy, strb, seen, bad_sel, lg_on = 0;
  int pre, stc, post, lg_cnt;

  always @(negedge clk) begin
    if (!rst) begin
      busy = (mem_be_n != '1);
      strb = !mem_re_n || !mem_we_n;
      if (busy) begin
        if (!was_busy) begin
          lg_on = 0;
          pre = 0; stc = 0; post = 0; seen = 0; bad_sel = 0;
          if (exq.size() == 0) begin
            chk(0, "R10", "unexpected bus cycle", 1, 0);
            cur = mk(0, 0, '0, '0, '0, 0);
          end else cur = exq[0];
        end
        if (strb) begin stc++; seen = 1; end
        else if (!seen) pre++;
        else post++;
        if (mem_addr != cur.addr || mem_be_n != ~cur.be ||
            mem_ce_n != ~(NUM_CS'(1) << cur.cs) || mem_oe_n != cur.we ||
            mem_dout_en != cur.we || (cur.we && mem_dout != cur.wd) ||
            ack || req_rdy || (cur.we ? !mem_re_n : !mem_we_n))
          bad_sel = 1;
      end else if (was_busy) begin
        chk(pre == cur.s, cur.we ? "R3/R4" : "R2/R4", "setup cycles", pre, cur.s);
        chk(stc == cur.str, cur.stag, "strobe cycles", stc, cur.str);
        chk(post == cur.h, cur.we ? "R3/R4" : "R2/R4", "hold cycles", post, cur.h);
        chk(!bad_sel, "R2/R3/R9/R10", "select signals during cycle", bad_sel, 0);
        chk(ack == 1'b1, "R7", "ack after last phase", ack, 1);
        if (!cur.we)
          chk(rdata == (DATA_W'(cur.addr) ^ MAGIC), "R7", "read data",
              rdata, DATA_W'(cur.addr) ^ MAGIC);
        chk(mem_oe_n && mem_re_n && mem_we_n && !mem_dout_en && mem_addr == '0,
            "R8", "selects released at end", 0, 0);
        if (exq.size() != 0) void'(exq.pop_front());
        lg_on = 1;
        lg_cnt = (mem_ce_n != '1) ? 1 : 0;
      end else if (lg_on) begin
        if (mem_ce_n != '1) lg_cnt++;
        else begin
          chk(lg_cnt == LINGER, "R8", "chip enable linger cycles", lg_cnt, LINGER);
          lg_on = 0;
        end
      end
      was_busy = busy;
    end
  end

  initial begin
    #(8ns * 150000);
    chk(0, "WATCHDOG", "run did not finish", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // space 0: normal, space 1: zero counts, space 2: short read / stretchable write, space 3: long
    cfgs[0] = '{wh:2, wst:2, ws:1, rh:1, rst:3, rs:2};
    cfgs[1] = '{wh:0, wst:4, ws:3, rh:0, rst:0, rs:0};
    cfgs[2] = '{wh:1, wst:3, ws:1, rh:1, rst:2, rs:1};
    cfgs[3] = '{wh:1, wst:2, ws:2, rh:3, rst:5, rs:4};
    repeat (4) @(negedge clk);
    // R1: outputs during reset
    chk(mem_ce_n == '1 && mem_be_n == '1 && mem_oe_n && mem_re_n && mem_we_n &&
        !mem_dout_en && !ack && req_rdy, "R1", "reset state", 0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_ce_n == '1 && !ack && req_rdy, "R1", "idle after reset", req_rdy, 1);

    xfer(0, 0, 20'h00123, 4'b1111, '0, 0);            // R2
    xfer(0, 1, 20'h00456, 4'b0011, 32'hDEAD_BEEF, 0); // R3
    xfer(1, 0, 20'h0AAAA, 4'b1000, '0, 0);            // R4 zero counts
    xfer(1, 1, 20'h05555, 4'b0100, 32'h1357_9BDF, 0); // R4 zero hold
    xfer(2, 0, 20'h00777, 4'b1111, '0, 20);           // R6 ready low ignored
    xfer(2, 1, 20'h00888, 4'b1111, 32'h0BAD_F00D, 2); // R5 stretched to 5
    xfer(2, 1, 20'h00999, 4'b0001, 32'h0000_0042, 1); // R5 stretched to 4
    xfer(3, 0, 20'h0F00F, 4'b1111, '0, 6);            // R5 stretched to 9
    xfer(3, 0, 20'h0F0F0, 4'b0110, '0, 1);            // R5 programmed end wins
    xfer(3, 1, 20'h03030, 4'b1111, 32'hCAFE_0001, 0); // R3
    // R9: back-to-back same space, then different spaces
    b2b(mk(0, 0, 20'h00010, 4'b1111, '0, 0), mk(0, 1, 20'h00011, 4'b1100, 32'h2468_ACE0, 0));
    b2b(mk(3, 0, 20'h00020, 4'b1111, '0, 0), mk(1, 1, 20'h00021, 4'b0011, 32'h1111_2222, 0));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule